// File: doc/BRIEF.md
# Single-Precision Reciprocal Estimate Unit

This unit takes one IEEE-754 single-precision operand per cycle and returns a coarse reciprocal with eight fraction bits. That is the seed a SIMD Newton-Raphson refinement loop starts from. The value is bit-exact and is not a true quotient. The top eight fraction bits of the operand pick one of 256 table entries. The table is built at elaboration from a fixed rounding formula. The result exponent is a plain subtraction from a constant.

Operands that are not normal, or whose exponent is too large for a normal reciprocal, are resolved inside the unit. NaNs, infinities, zeros, denormals and huge magnitudes each map to a fixed result class. Three exception outputs report invalid, divide-by-zero and underflow. They are high only in the cycle that carries the matching result. The result is registered, so each accepted operand appears one clock later.

Top module: `recip_est_unit`

## Requirements
- R1: Any NaN operand (exponent field 0xFF, fraction non-zero) yields 32'h7FC00000: sign 0, exponent all ones, only fraction bit 22 set.
- R2: A signaling NaN (exponent 0xFF, fraction non-zero, fraction bit 22 clear) raises flagInvalid. A quiet NaN (bit 22 set) raises no flag.
- R3: An infinite operand yields zero with the operand's sign bit, and raises no flag.
- R4: A zero or denormal operand (exponent field 0) yields infinity with the operand's sign (exponent 0xFF, fraction 0) and raises flagDivZero.
- R5: An operand with biased exponent 253 or 254 yields zero with the operand's sign and raises flagUnderflow.
- R6: For a normal operand with exponent 1..252, let q = 256 + operand[22:15]. Then s = floor(256 / ((q + 0.5) / 512) + 0.5) lies in 256..511. Result bits 22:15 hold s[7:0], and result bits 14:0 are zero. Operand bits 14:0 have no effect.
- R7: For such a normal operand, the result exponent is 253 minus the operand exponent, and the result sign equals the operand sign. No flag is raised.
- R8: outValid and the result appear on the first rising edge after the one that samples inValid high. During reset, outValid, outResult and all flags are zero.
- R9: A flag is high only while outValid is high, and at most one flag is high at a time.
- R10: A cycle with inValid low leaves outResult unchanged, and outValid is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operand strobe |
| inOperand | input | 32 | Single-precision operand |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| outResult | output | 32 | Reciprocal estimate or special result |
| flagInvalid | output | 1 | Signaling NaN seen |
| flagDivZero | output | 1 | Zero or denormal operand |
| flagUnderflow | output | 1 | Exponent 253 or more |

## Verification
Every result, including its flag, is due exactly one clock after the edge that samples the operand. Nothing in the unit takes longer than one cycle. The bench drives on the falling edge and computes the expected value right after the capturing rising edge. It compares at the next falling edge, before it drives the next operand. Idle cycles are mixed in to check that outValid and the flags fall one cycle after the strobe drops, and that the held result stays unchanged.

// File: rtl/recip_pkg.sv
package recip_pkg;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int SP_W      = 1 + SP_EXP_W + SP_FRAC_W;
  localparam logic [SP_W-1:0] DEFAULT_QNAN = 32'h7FC00000;

  typedef struct packed {
    logic load;
    logic selNan;
    logic selZero;
    logic selInf;
    logic selEst;
    logic raiseInvalid;
    logic raiseDivZero;
    logic raiseUnderflow;
  } ctrl_t;
endpackage

// File: rtl/recip_table.sv
module recip_table #(
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] estFrac
);
  localparam int  N    = 1 << IDX_W;
  localparam longint NL = longint'(N);

  // s = round(N*2N/(q+0.5)) = floor((8N^2 + 2q+1) / (2(2q+1))), q in [N,2N)
  function automatic logic [IDX_W-1:0] calcEntry(input int q);
    longint num;
    longint den;
    longint s;
    num = 8 * NL * NL + 2 * longint'(q) + 1;
    den = 2 * (2 * longint'(q) + 1);
    s   = num / den - NL;
    return s[IDX_W-1:0];
  endfunction

  logic [IDX_W-1:0] lut [N];

  for (genvar i = 0; i < N; i++) begin : g_entry
    assign lut[i] = calcEntry(N + i);
  end

  assign estFrac = lut[idx];
endmodule

// File: rtl/recip_ctrl.sv
module recip_ctrl
  import recip_pkg::*;
#(
  parameter int BIG_EXP = 253
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [SP_W-1:0] operand,
  output ctrl_t           ctl
);
  logic [SP_EXP_W-1:0] opExp;
  logic [SP_FRAC_W-1:0] opFrac;
  logic expOnes, expZero, fracZero, expBig, isNan;

  assign opExp    = operand[SP_W-2 -: SP_EXP_W];
  assign opFrac   = operand[SP_FRAC_W-1:0];
  assign expOnes  = &opExp;
  assign expZero  = ~|opExp;
  assign fracZero = ~|opFrac;
  assign expBig   = !expOnes && (opExp >= SP_EXP_W'(BIG_EXP));
  assign isNan    = expOnes && !fracZero;

  always_comb begin
    ctl                = '0;
    ctl.load           = inValid;
    ctl.selNan         = inValid && isNan;
    ctl.selInf         = inValid && expZero;
    ctl.selZero        = inValid && ((expOnes && fracZero) || expBig);
    ctl.selEst         = inValid && !expOnes && !expZero && !expBig;
    ctl.raiseInvalid   = ctl.selNan && !opFrac[SP_FRAC_W-1];
    ctl.raiseDivZero   = ctl.selInf;
    ctl.raiseUnderflow = inValid && expBig;
  end

  p_one_path_r9: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> $onehot({ctl.selNan, ctl.selZero, ctl.selInf, ctl.selEst}));
  p_no_select_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> !(ctl.selNan || ctl.selZero || ctl.selInf || ctl.selEst));
endmodule

// File: rtl/recip_datapath.sv
module recip_datapath
  import recip_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int EXP_SUM = 253
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrl_t           ctl,
  input  logic [SP_W-1:0] operand,
  output logic            outValid,
  output logic [SP_W-1:0] outResult,
  output logic [2:0]      outFlags
);
  localparam int PAD_W = SP_FRAC_W - IDX_W;

  logic                 opSign;
  logic [SP_EXP_W-1:0]  opExp;
  logic [IDX_W-1:0]     tblIdx;
  logic [IDX_W-1:0]     estFrac;
  logic [SP_EXP_W-1:0]  estExp;
  logic [SP_W-1:0]      nextResult;

  assign opSign = operand[SP_W-1];
  assign opExp  = operand[SP_W-2 -: SP_EXP_W];
  assign tblIdx = operand[SP_FRAC_W-1 -: IDX_W];
  assign estExp = SP_EXP_W'(EXP_SUM) - opExp;

  recip_table #(.IDX_W(IDX_W)) u_table (
    .idx     (tblIdx),
    .estFrac (estFrac)
  );

  always_comb begin
    nextResult = '0;
    if (ctl.selNan)       nextResult = DEFAULT_QNAN;
    else if (ctl.selInf)  nextResult = {opSign, {SP_EXP_W{1'b1}}, {SP_FRAC_W{1'b0}}};
    else if (ctl.selZero) nextResult = {opSign, {(SP_W-1){1'b0}}};
    else if (ctl.selEst)  nextResult = {opSign, estExp, estFrac, {PAD_W{1'b0}}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outResult <= '0;
      outFlags  <= '0;
    end else begin
      outValid <= ctl.load;
      outFlags <= ctl.load ? {ctl.raiseInvalid, ctl.raiseDivZero, ctl.raiseUnderflow} : 3'b000;
      if (ctl.load) outResult <= nextResult;
    end
  end

  p_flag_needs_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (outFlags == 3'b000));
  p_flags_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(outFlags));
  p_nan_result_r1: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outFlags[2]) |-> (outResult == DEFAULT_QNAN));
  p_divzero_inf_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outFlags[1]) |-> (outResult[SP_W-2:0] == {{SP_EXP_W{1'b1}}, {SP_FRAC_W{1'b0}}}));
  p_underflow_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outFlags[0]) |-> (outResult[SP_W-2:0] == '0));
  p_est_tail_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outResult[SP_W-2 -: SP_EXP_W] != '0 && outResult[SP_W-2 -: SP_EXP_W] <= SP_EXP_W'(EXP_SUM - 1))
      |-> (outResult[PAD_W-1:0] == '0));
endmodule

// File: rtl/recip_est_unit.sv
module recip_est_unit
  import recip_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int EXP_SUM = 253
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] inOperand,
  output logic        outValid,
  output logic [31:0] outResult,
  output logic        flagInvalid,
  output logic        flagDivZero,
  output logic        flagUnderflow
);
  ctrl_t      ctl;
  logic [2:0] flags;

  recip_ctrl #(.BIG_EXP(EXP_SUM)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .operand (inOperand),
    .ctl     (ctl)
  );

  recip_datapath #(.IDX_W(IDX_W), .EXP_SUM(EXP_SUM)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .operand   (inOperand),
    .outValid  (outValid),
    .outResult (outResult),
    .outFlags  (flags)
  );

  assign flagInvalid   = flags[2];
  assign flagDivZero   = flags[1];
  assign flagUnderflow = flags[0];

  p_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outResult) && !outValid));
endmodule

// File: tb/recip_est_unit_tb.sv
`timescale 1ns/1ps
module recip_est_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inOperand = '0;
  logic        outValid;
  logic [31:0] outResult;
  logic        flagInvalid, flagDivZero, flagUnderflow;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [31:0] expRes = '0;
  logic [2:0]  expFlags = '0;
  logic        expValid = 1'b0;
  string       expTag = "R8";
  bit          expNormal = 0;

  always #2.5 clk = ~clk;

  recip_est_unit u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOperand(inOperand),
    .outValid(outValid), .outResult(outResult), .flagInvalid(flagInvalid),
    .flagDivZero(flagDivZero), .flagUnderflow(flagUnderflow)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h (operand %h)", tag, act, exp, inOperand);
    end
  endtask

  // behavioural model from the requirements
  task automatic model(input logic [31:0] a);
    int e, q, s;
    real r;
    e = a[30:23];
    expFlags = 3'b000;
    expNormal = 0;
    if (e == 255 && a[22:0] != 0) begin
      expRes = 32'h7FC00000;
      expFlags = {~a[22], 2'b00};
      expTag = a[22] ? "R1" : "R2";
    end else if (e == 255) begin
      expRes = {a[31], 31'd0};
      expTag = "R3";
    end else if (e == 0) begin
      expRes = {a[31], 8'hFF, 23'd0};
      expFlags = 3'b010;
      expTag = "R4";
    end else if (e >= 253) begin
      expRes = {a[31], 31'd0};
      expFlags = 3'b001;
      expTag = "R5";
    end else begin
      q = 256 + int'(a[22:15]);
      r = 1.0 / ((q + 0.5) / 512.0);
      s = $rtoi($floor(256.0 * r + 0.5));
      expRes = {a[31], 8'(253 - e), 8'(s), 15'd0};
      expTag = "R6";
      expNormal = 1;
    end
  endtask

  task automatic step(input logic v, input logic [31:0] a);
    inValid = v;
    inOperand = a;
    @(posedge clk);
    expValid = v;
    if (v) model(a);
    else expFlags = 3'b000;
    @(negedge clk);
    check("R8", 64'(outValid), 64'(expValid));
    if (v) begin
      if (expNormal) begin
        check("R6", 64'(outResult[22:0]), 64'(expRes[22:0]));
        check("R7", 64'({outResult[31:23], flagInvalid, flagDivZero, flagUnderflow}),
                    64'({expRes[31:23], expFlags}));
      end else begin
        check(expTag, 64'({outResult, flagInvalid, flagDivZero, flagUnderflow}),
                      64'({expRes, expFlags}));
      end
    end else begin
      check("R10", 64'(outResult), 64'(expRes));
      check("R9", 64'({flagInvalid, flagDivZero, flagUnderflow}), 64'(3'b000));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8", 64'({outValid, outResult, flagInvalid, flagDivZero, flagUnderflow}), 64'(0));
    rstN = 1'b1;
    @(negedge clk);

    // R6/R7: every table index, with varied exponent, sign and ignored low bits
    for (int i = 0; i < 256; i++) begin
      logic [7:0] ex;
      ex = 8'(1 + (i * 37) % 252);
      step(1'b1, {i[0], ex, 8'(i), 15'($urandom)});
      if (i % 16 == 15) step(1'b0, $urandom);
    end
    // R6: low operand bits have no effect
    step(1'b1, {1'b0, 8'd127, 8'h5A, 15'h0000});
    step(1'b1, {1'b0, 8'd127, 8'h5A, 15'h7FFF});
    // R7: exponent boundaries
    step(1'b1, {1'b0, 8'd1, 23'h000000});
    step(1'b1, {1'b1, 8'd252, 23'h7FFFFF});
    step(1'b1, {1'b0, 8'd126, 23'h400000});
    // R1/R2: NaNs
    step(1'b1, 32'h7FC00000);
    step(1'b1, 32'hFFC00001);
    step(1'b1, 32'h7F800001);
    step(1'b1, 32'hFFA00000);
    step(1'b0, 32'h7F800001);
    // R3: infinities
    step(1'b1, 32'h7F800000);
    step(1'b1, 32'hFF800000);
    // R4: zeros and denormals
    step(1'b1, 32'h00000000);
    step(1'b1, 32'h80000000);
    step(1'b1, 32'h00000001);
    step(1'b1, 32'h807FFFFF);
    // R5: huge exponents
    step(1'b1, {1'b0, 8'd253, 23'h000000});
    step(1'b1, {1'b1, 8'd254, 23'h7FFFFF});
    // R10/R9: idle after a flagged result
    step(1'b0, 32'h00000000);
    step(1'b0, 32'h7F800001);
    // mixed random traffic
    for (int k = 0; k < 400; k++) begin
      step(($urandom % 4) != 0, $urandom);
    end
    step(1'b0, '0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule